// File: doc/BRIEF.md
# Pilot-Aided Rake Channel Estimator and Combiner

This block is the combining stage of a multipath spread-spectrum receiver. It takes one complex sample per chip, removes the slowly varying DC offset, and feeds a short delay line. Each rake finger reads that line at its own path delay, multiplies by the spreading code and sums a spreading factor's worth of chips into a despread symbol. The pilot symbols of a slot give each finger a complex channel estimate. In the output, every finger's symbol is weighted by the conjugate of that estimate and all fingers are summed.

Two estimation modes are offered. For a static channel the estimate keeps growing over the pilots of every slot received so far. For a fading channel it is rebuilt from the current slot's pilots only. In both modes the whole slot of despread symbols is held in a ping-pong buffer, so the estimate can be applied to symbols that arrived before the pilots were complete. A known channel sequence supplied from outside, aligned by a programmable sample offset, can replace the internal estimate. Alongside the symbols the block reports one channel value per finger for every chip.

Top module: `pilot_mrc_rake`

## Requirements
- R1: After reset, `sym_valid` and `chan_valid` are low and stay low until samples are processed.
- R2: The DC estimate is taken from a per-rail accumulator A that starts at 0. For each valid sample x, the corrected value is c = x - (A >>> DCS), and A then becomes A + c. Only corrected values enter the fingers.
- R3: Counting valid samples from 0, the reference stream (code, pilot, slot-first) for chip p pairs with corrected sample p + d for a finger with delay d (0 to MAXD). A code bit of 1 negates the chip and 0 keeps it. Cycles with `smp_valid` low are ignored.
- R4: A symbol is the sum of SF consecutive signed chips. Chip counting restarts at each chip flagged `slot_first`, and a slot is SPS symbols long. A symbol counts as pilot when `pilot_chip` is set on its first chip, and every pilot symbol is taken as transmitted with value +1.
- R5: In fading mode (`fading_mode`=1 at slot end), a finger's estimate for a slot is the sum of that slot's despread pilot symbols.
- R6: In static mode, a finger's estimate is the sum of the despread pilot symbols of all slots since reset, including the current one.
- R7: After a slot completes, its data symbols (not pilots) are emitted in order. For each one, `sym_i` + j`sym_q` equals the sum over all NF fingers of conj(w) times y. Every finger is included.
- R8: With `use_ext` high at slot end, the weight w of each symbol is the external value of that finger at sample index p + `ext_offset`, where p is the symbol's first chip.
- R9: For every chip processed after sync, `chan_valid` pulses once with one value per finger. With `use_ext` high the value is the aligned external value of that chip. Otherwise it is the internal estimate of the previous completed slot, or 0 during the first slot.
- R10: Chips before the first `slot_first` produce no symbol and no channel output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Chip sample present this cycle |
| smp_i | input | W | Received in-phase sample, signed |
| smp_q | input | W | Received quadrature sample, signed |
| code_chip | input | 1 | Spreading code bit for this chip (1 negates) |
| pilot_chip | input | 1 | Chip belongs to a pilot symbol |
| slot_first | input | 1 | First chip of a slot |
| fading_mode | input | 1 | 1 selects the per-slot estimate, 0 the cumulative one |
| use_ext | input | 1 | Use the external channel values instead of the internal estimate |
| ext_offset | input | clog2(MAXD+1) | Lead of the external channel stream over the code, in samples |
| finger_dly | input | NF*clog2(MAXD+1) | Per-finger path delay, finger 0 in the low bits |
| ext_i | input | NF*EW | External channel, in-phase, per finger |
| ext_q | input | NF*EW | External channel, quadrature, per finger |
| sym_valid | output | 1 | Combined data symbol present |
| sym_i | output | OW | Combined symbol, real part |
| sym_q | output | OW | Combined symbol, imaginary part |
| chan_valid | output | 1 | Per-chip channel values present |
| chan_i | output | NF*HW | Channel value, in-phase, per finger |
| chan_q | output | NF*HW | Channel value, quadrature, per finger |

## Verification
The hardest condition to reach from the ports is a slot whose pilots and data are spread across several path delays while `smp_valid` has gaps and the DC tracker is still settling. Every finger then despreads a different slice of partly corrected samples, and any misalignment of one sample changes the sums. The bench drives whole multi-slot runs with random codes, an added DC offset, several delay and pilot-position patterns, periodic idle cycles and both external offsets up to MAXD. It computes every symbol and every per-chip channel value arithmetically from the requirements.

// File: rtl/pilot_mrc_rake.sv
module pilot_mrc_rake #(
  parameter int W    = 8,
  parameter int NF   = 2,
  parameter int SF   = 256,
  parameter int SPS  = 10,
  parameter int MAXD = 15,
  parameter int DCS  = 6,
  parameter int EW   = 8,
  parameter int HACC = 16,
  localparam int DLW = $clog2(MAXD + 1),
  localparam int YW  = W + 1 + $clog2(SF),
  localparam int HW  = YW + HACC,
  localparam int OW  = HW + YW + 1 + $clog2(NF)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_valid,
  input  logic signed [W-1:0]    smp_i,
  input  logic signed [W-1:0]    smp_q,
  input  logic                   code_chip,
  input  logic                   pilot_chip,
  input  logic                   slot_first,
  input  logic                   fading_mode,
  input  logic                   use_ext,
  input  logic [DLW-1:0]         ext_offset,
  input  logic [NF*DLW-1:0]      finger_dly,
  input  logic [NF*EW-1:0]       ext_i,
  input  logic [NF*EW-1:0]       ext_q,
  output logic                   sym_valid,
  output logic signed [OW-1:0]   sym_i,
  output logic signed [OW-1:0]   sym_q,
  output logic                   chan_valid,
  output logic [NF*HW-1:0]       chan_i,
  output logic [NF*HW-1:0]       chan_q
);

  localparam int CW  = W + 1;
  localparam int AW  = W + DCS + 1;
  localparam int SCW = $clog2(SF);
  localparam int SPW = $clog2(SPS);

  // DC tracking
  logic signed [AW-1:0] acc_i, acc_q;
  logic signed [AW-1:0] dcf_i, dcf_q;
  logic signed [CW-1:0] cor_i, cor_q;
  assign dcf_i = acc_i >>> DCS;
  assign dcf_q = acc_q >>> DCS;
  assign cor_i = CW'(smp_i) - CW'(dcf_i);
  assign cor_q = CW'(smp_q) - CW'(dcf_q);

  // delay lines
  logic signed [CW-1:0] dl_i [1:MAXD];
  logic signed [CW-1:0] dl_q [1:MAXD];
  logic signed [CW-1:0] tp_i [0:MAXD];
  logic signed [CW-1:0] tp_q [0:MAXD];
  logic [2:0]           rf   [1:MAXD];
  logic signed [EW-1:0] xd_i [NF][1:MAXD];
  logic signed [EW-1:0] xd_q [NF][1:MAXD];
  logic signed [EW-1:0] xt_i [NF][0:MAXD];
  logic signed [EW-1:0] xt_q [NF][0:MAXD];

  always_comb begin
    tp_i[0] = cor_i;
    tp_q[0] = cor_q;
    for (int k = 1; k <= MAXD; k++) begin
      tp_i[k] = dl_i[k];
      tp_q[k] = dl_q[k];
    end
    for (int f = 0; f < NF; f++) begin
      xt_i[f][0] = ext_i[f*EW +: EW];
      xt_q[f][0] = ext_q[f*EW +: EW];
      for (int k = 1; k <= MAXD; k++) begin
        xt_i[f][k] = xd_i[f][k];
        xt_q[f][k] = xd_q[f][k];
      end
    end
  end

  wire rc_code  = rf[MAXD][2];
  wire rc_pil   = rf[MAXD][1];
  wire rc_first = rf[MAXD][0];

  // chip and symbol position
  logic           synced;
  logic [SCW-1:0] cc;
  logic [SPW-1:0] sc;
  logic [SCW-1:0] pos_c;
  logic [SPW-1:0] pos_s;
  assign pos_c = rc_first ? '0 : cc;
  assign pos_s = rc_first ? '0 : sc;
  wire chip_on  = smp_valid && (synced || rc_first);
  wire sym_done = chip_on && (pos_c == SCW'(SF - 1));
  wire slot_end = sym_done && (pos_s == SPW'(SPS - 1));

  // per-finger despreading and estimation
  logic signed [CW-1:0] fs_i [NF], fs_q [NF];
  logic signed [CW-1:0] sv_i [NF], sv_q [NF];
  logic signed [YW-1:0] da_i [NF], da_q [NF];
  logic signed [YW-1:0] ys_i [NF], ys_q [NF];
  logic signed [EW-1:0] wl_i [NF], wl_q [NF];
  logic signed [EW-1:0] cw_i [NF], cw_q [NF];
  logic signed [HW-1:0] h_i  [NF], h_q  [NF];
  logic signed [HW-1:0] hn_i [NF], hn_q [NF];
  logic signed [HW-1:0] hw_i [NF], hw_q [NF];
  logic                 pil_l;
  wire cur_pil = (pos_c == '0) ? rc_pil : pil_l;
  wire [31:0] xsel = MAXD - int'(ext_offset);

  always_comb begin
    for (int f = 0; f < NF; f++) begin
      fs_i[f] = tp_i[MAXD - int'(finger_dly[f*DLW +: DLW])];
      fs_q[f] = tp_q[MAXD - int'(finger_dly[f*DLW +: DLW])];
      sv_i[f] = rc_code ? -fs_i[f] : fs_i[f];
      sv_q[f] = rc_code ? -fs_q[f] : fs_q[f];
      ys_i[f] = ((pos_c == '0) ? '0 : da_i[f]) + YW'(sv_i[f]);
      ys_q[f] = ((pos_c == '0) ? '0 : da_q[f]) + YW'(sv_q[f]);
      cw_i[f] = (pos_c == '0) ? xt_i[f][xsel] : wl_i[f];
      cw_q[f] = (pos_c == '0) ? xt_q[f][xsel] : wl_q[f];
      hn_i[f] = h_i[f] + ((sym_done && cur_pil) ? HW'(ys_i[f]) : '0);
      hn_q[f] = h_q[f] + ((sym_done && cur_pil) ? HW'(ys_q[f]) : '0);
    end
  end

  // slot buffers
  logic signed [YW-1:0] by_i [2][SPS][NF];
  logic signed [YW-1:0] by_q [2][SPS][NF];
  logic signed [EW-1:0] bw_i [2][SPS][NF];
  logic signed [EW-1:0] bw_q [2][SPS][NF];
  logic                 bp   [2][SPS];
  logic           wb, rb, rd_active, sel_ext;
  logic [SPW-1:0] rd_idx;

  always_ff @(posedge clk) begin
    if (sym_done) begin
      bp[wb][pos_s] <= cur_pil;
      for (int f = 0; f < NF; f++) begin
        by_i[wb][pos_s][f] <= ys_i[f];
        by_q[wb][pos_s][f] <= ys_q[f];
        bw_i[wb][pos_s][f] <= cw_i[f];
        bw_q[wb][pos_s][f] <= cw_q[f];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_i <= '0; acc_q <= '0;
      synced <= 1'b0; cc <= '0; sc <= '0; pil_l <= 1'b0;
      wb <= 1'b0; rb <= 1'b0; rd_active <= 1'b0; rd_idx <= '0; sel_ext <= 1'b0;
      chan_valid <= 1'b0; chan_i <= '0; chan_q <= '0;
      for (int k = 1; k <= MAXD; k++) begin
        dl_i[k] <= '0; dl_q[k] <= '0; rf[k] <= '0;
        for (int f = 0; f < NF; f++) begin
          xd_i[f][k] <= '0; xd_q[f][k] <= '0;
        end
      end
      for (int f = 0; f < NF; f++) begin
        da_i[f] <= '0; da_q[f] <= '0; wl_i[f] <= '0; wl_q[f] <= '0;
        h_i[f] <= '0; h_q[f] <= '0; hw_i[f] <= '0; hw_q[f] <= '0;
      end
    end else begin
      if (rd_active) begin
        rd_idx <= rd_idx + 1'b1;
        if (rd_idx == SPW'(SPS - 1)) rd_active <= 1'b0;
      end
      chan_valid <= chip_on;
      if (smp_valid) begin
        acc_i <= acc_i + AW'(cor_i);
        acc_q <= acc_q + AW'(cor_q);
        dl_i[1] <= cor_i; dl_q[1] <= cor_q;
        rf[1] <= {code_chip, pilot_chip, slot_first};
        for (int k = 2; k <= MAXD; k++) begin
          dl_i[k] <= dl_i[k-1]; dl_q[k] <= dl_q[k-1]; rf[k] <= rf[k-1];
        end
        for (int f = 0; f < NF; f++) begin
          xd_i[f][1] <= xt_i[f][0]; xd_q[f][1] <= xt_q[f][0];
          for (int k = 2; k <= MAXD; k++) begin
            xd_i[f][k] <= xd_i[f][k-1]; xd_q[f][k] <= xd_q[f][k-1];
          end
        end
      end
      if (chip_on) begin
        synced <= 1'b1;
        pil_l  <= cur_pil;
        if (pos_c == SCW'(SF - 1)) begin
          cc <= '0;
          sc <= (pos_s == SPW'(SPS - 1)) ? '0 : pos_s + 1'b1;
        end else begin
          cc <= pos_c + 1'b1;
          sc <= pos_s;
        end
        for (int f = 0; f < NF; f++) begin
          da_i[f] <= ys_i[f]; da_q[f] <= ys_q[f];
          wl_i[f] <= cw_i[f]; wl_q[f] <= cw_q[f];
          h_i[f]  <= (slot_end && fading_mode) ? '0 : hn_i[f];
          h_q[f]  <= (slot_end && fading_mode) ? '0 : hn_q[f];
          chan_i[f*HW +: HW] <= use_ext ? HW'(xt_i[f][xsel]) : hw_i[f];
          chan_q[f*HW +: HW] <= use_ext ? HW'(xt_q[f][xsel]) : hw_q[f];
          if (slot_end) begin
            hw_i[f] <= hn_i[f]; hw_q[f] <= hn_q[f];
          end
        end
        if (slot_end) begin
          wb <= ~wb; rb <= wb; rd_active <= 1'b1; rd_idx <= '0; sel_ext <= use_ext;
        end
      end
    end
  end

  // conjugate-weighted combining of all fingers
  logic signed [OW-1:0] cre, cim, wi, wq, yi, yq;
  always_comb begin
    cre = '0; cim = '0;
    wi = '0; wq = '0; yi = '0; yq = '0;
    for (int f = 0; f < NF; f++) begin
      wi = sel_ext ? OW'(bw_i[rb][rd_idx][f]) : OW'(hw_i[f]);
      wq = sel_ext ? OW'(bw_q[rb][rd_idx][f]) : OW'(hw_q[f]);
      yi = OW'(by_i[rb][rd_idx][f]);
      yq = OW'(by_q[rb][rd_idx][f]);
      cre = cre + wi * yi + wq * yq;
      cim = cim + wi * yq - wq * yi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_valid <= 1'b0; sym_i <= '0; sym_q <= '0;
    end else begin
      sym_valid <= rd_active && !bp[rb][rd_idx];
      sym_i <= cre;
      sym_q <= cim;
    end
  end

  assert_dc_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dcf_i >= -(2**(W-1)) && dcf_i <= 2**(W-1) - 1 && dcf_q >= -(2**(W-1)) && dcf_q <= 2**(W-1) - 1);

  assert_chan_on_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_valid |-> $past(smp_valid));

  assert_silent_unsynced_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> (!sym_valid && !chan_valid));

  assert_read_clear_at_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> (!rd_active || rd_idx == SPW'(SPS - 1)));

  assert_read_after_chip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active) |-> $past(smp_valid));

endmodule

// File: tb/tb_pilot_mrc_rake.sv
module tb_pilot_mrc_rake;
  localparam int W = 8, NF = 2, SF = 4, SPS = 4, MAXD = 3, DCS = 4, EW = 8, HACC = 16;
  localparam int DLW = 2, YW = W + 1 + 2, HW = YW + HACC, OW = HW + YW + 1 + 1;
  localparam int SL = SF * SPS, P0 = 2, NMAX = 256;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, code_chip = 0, pilot_chip = 0, slot_first = 0, fading_mode = 0, use_ext = 0;
  logic signed [W-1:0] smp_i = 0, smp_q = 0;
  logic [DLW-1:0] ext_offset = 0;
  logic [NF*DLW-1:0] finger_dly = 0;
  logic [NF*EW-1:0] ext_i = 0, ext_q = 0;
  logic sym_valid, chan_valid;
  logic signed [OW-1:0] sym_i, sym_q;
  logic [NF*HW-1:0] chan_i, chan_q;

  always #2 clk = ~clk;

  pilot_mrc_rake #(.W(W), .NF(NF), .SF(SF), .SPS(SPS), .MAXD(MAXD), .DCS(DCS), .EW(EW), .HACC(HACC)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .code_chip(code_chip), .pilot_chip(pilot_chip), .slot_first(slot_first),
    .fading_mode(fading_mode), .use_ext(use_ext), .ext_offset(ext_offset),
    .finger_dly(finger_dly), .ext_i(ext_i), .ext_q(ext_q),
    .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q),
    .chan_valid(chan_valid), .chan_i(chan_i), .chan_q(chan_q));

  int nchk = 0, nfail = 0;
  bit done = 0;
  int xi[NMAX], xq[NMAX], cd[NMAX], pl[NMAX], fr[NMAX];
  int ei[NMAX][NF], eq[NMAX][NF];
  longint ci[NMAX], cq[NMAX];
  longint cs_i[NMAX], cs_q[NMAX];
  longint ch_i[NMAX][NF], ch_q[NMAX][NF];
  int ns = 0, nc = 0;

  task automatic chk(bit ok, string req, longint got, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (sym_valid && ns < NMAX) begin
      cs_i[ns] = $signed(sym_i); cs_q[ns] = $signed(sym_q); ns++;
    end
    if (chan_valid && nc < NMAX) begin
      for (int f = 0; f < NF; f++) begin
        ch_i[nc][f] = $signed(chan_i[f*HW +: HW]);
        ch_q[nc][f] = $signed(chan_q[f*HW +: HW]);
      end
      nc++;
    end
  end

  task automatic run(bit fad, bit ext, int off, int d0, int d1, bit [3:0] pat, bit gaps, int nsl, int dco);
    int nt, pmax, ne, cyc, d[NF];
    longint acc_i, acc_q, hs_i[8][NF], hs_q[8][NF], es_i[NMAX], es_q[NMAX];
    string tag;
    d[0] = d0; d[1] = d1;
    nt = P0 + SL * nsl + MAXD + 3;
    pmax = nt - 1 - MAXD;
    for (int t = 0; t < nt; t++) begin
      xi[t] = int'($urandom_range(0, 120)) - 60 + dco;
      xq[t] = int'($urandom_range(0, 120)) - 60 - dco;
      cd[t] = int'($urandom_range(0, 1));
      fr[t] = (t >= P0 && (t - P0) % SL == 0 && (t - P0) / SL < nsl) ? 1 : 0;
      pl[t] = (t >= P0) ? int'(pat[((t - P0) % SL) / SF]) : 0;
      for (int f = 0; f < NF; f++) begin
        ei[t][f] = int'($urandom_range(0, 200)) - 100;
        eq[t][f] = int'($urandom_range(0, 200)) - 100;
      end
    end
    rst_n = 0; smp_valid = 0;
    fading_mode = fad; use_ext = ext; ext_offset = DLW'(off);
    finger_dly = {DLW'(d1), DLW'(d0)};
    repeat (3) @(negedge clk);
    chk(!sym_valid && !chan_valid, "R1 outputs idle in reset", {sym_valid, chan_valid}, 0);
    rst_n = 1; ns = 0; nc = 0;
    @(negedge clk);
    chk(!sym_valid && !chan_valid, "R1 outputs idle after reset", {sym_valid, chan_valid}, 0);
    cyc = 0;
    for (int t = 0; t < nt; t++) begin
      if (gaps && cyc % 3 == 2) begin
        smp_valid = 0; smp_i = 8'sd77; code_chip = 1; slot_first = 1;
        @(negedge clk); cyc++;
      end
      smp_valid = 1; smp_i = W'(xi[t]); smp_q = W'(xq[t]);
      code_chip = cd[t][0]; pilot_chip = pl[t][0]; slot_first = fr[t][0];
      for (int f = 0; f < NF; f++) begin
        ext_i[f*EW +: EW] = EW'(ei[t][f]); ext_q[f*EW +: EW] = EW'(eq[t][f]);
      end
      @(negedge clk); cyc++;
    end
    smp_valid = 0; slot_first = 0;
    repeat (20) @(negedge clk);

    // model
    acc_i = 0; acc_q = 0;
    for (int t = 0; t < nt; t++) begin
      ci[t] = xi[t] - (acc_i >>> DCS); acc_i += ci[t];
      cq[t] = xq[t] - (acc_q >>> DCS); acc_q += cq[t];
    end
    ne = 0;
    for (int k = 0; k < nsl; k++) begin
      longint yi[SPS][NF], yq[SPS][NF];
      for (int j = 0; j < SPS; j++)
        for (int f = 0; f < NF; f++) begin
          yi[j][f] = 0; yq[j][f] = 0;
          for (int c = 0; c < SF; c++) begin
            int p = P0 + SL * k + SF * j + c;
            yi[j][f] += cd[p] ? -ci[p + d[f]] : ci[p + d[f]];
            yq[j][f] += cd[p] ? -cq[p + d[f]] : cq[p + d[f]];
          end
        end
      for (int f = 0; f < NF; f++) begin
        hs_i[k][f] = (fad || k == 0) ? 0 : hs_i[k-1][f];
        hs_q[k][f] = (fad || k == 0) ? 0 : hs_q[k-1][f];
        for (int j = 0; j < SPS; j++)
          if (pat[j]) begin hs_i[k][f] += yi[j][f]; hs_q[k][f] += yq[j][f]; end
      end
      for (int j = 0; j < SPS; j++)
        if (!pat[j]) begin
          es_i[ne] = 0; es_q[ne] = 0;
          for (int f = 0; f < NF; f++) begin
            longint wi, wq;
            int b = P0 + SL * k + SF * j + off;
            wi = ext ? ei[b][f] : hs_i[k][f];
            wq = ext ? eq[b][f] : hs_q[k][f];
            es_i[ne] += wi * yi[j][f] + wq * yq[j][f];
            es_q[ne] += wi * yq[j][f] - wq * yi[j][f];
          end
          ne++;
        end
    end
    tag = ext ? "R2 R3 R4 R7 R8" : (fad ? "R2 R3 R4 R5 R7" : "R2 R3 R4 R6 R7");
    chk(ns == ne, "R7 data symbol count", ns, ne);
    for (int i = 0; i < ne && i < ns; i++) begin
      chk(cs_i[i] == es_i[i], {tag, " combined real"}, cs_i[i], es_i[i]);
      chk(cs_q[i] == es_q[i], {tag, " combined imag"}, cs_q[i], es_q[i]);
    end
    chk(nc == pmax - P0 + 1, "R9 R10 channel value count", nc, pmax - P0 + 1);
    for (int n = 0; n < nc && n <= pmax - P0; n++) begin
      int p = P0 + n;
      int k = n / SL;
      for (int f = 0; f < NF; f++) begin
        longint vi, vq;
        if (ext) begin vi = ei[p + off][f]; vq = eq[p + off][f]; end
        else if (k == 0) begin vi = 0; vq = 0; end
        else begin vi = hs_i[k-1][f]; vq = hs_q[k-1][f]; end
        chk(ch_i[n][f] == vi, "R9 channel value in-phase", ch_i[n][f], vi);
        chk(ch_q[n][f] == vq, "R9 channel value quadrature", ch_q[n][f], vq);
      end
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    run(0, 0, 0, 0, 2, 4'b0011, 0, 5, 20);
    run(1, 0, 0, 3, 1, 4'b1001, 1, 5, -15);
    run(1, 1, 2, 1, 0, 4'b0001, 0, 4, 30);
    run(0, 1, 3, 3, 3, 4'b0101, 1, 4, 0);
    run(0, 0, 1, 2, 0, 4'b1110, 1, 6, 40);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R1 watchdog: got 0 expected 1 completed runs");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule